// File: doc/BRIEF.md
# Mixed-Sign Indexed Byte Dot-Product Accumulator

This unit performs packed four-way byte dot products and accumulates them into a vector of 32-bit lanes. Every destination lane takes its four signed bytes from the first source and pairs them with the four unsigned bytes of a single 32-bit word. That word is picked out of the second source by a 2-bit index, and the same word serves every lane. Each lane adds its four products to the matching lane of the accumulator input, and the sum wraps.

A width select chooses between four lanes (128-bit operation) and two lanes (64-bit operation). The result is registered, so it appears on the output together with a valid flag one clock after the input strobe. The unit has no flags or status outputs. It is meant to sit in a SIMD execution pipe that feeds it operands read from a register file and writes back its result.

Top module: `mixdot_unit`

## Requirements
- R1: For each active lane e, the result equals the accumulator lane plus the sum over b = 0..3 of byte (4e+b) of `src_s` multiplied by byte b of the selected word. All arithmetic is modulo 2^32.
- R2: Bytes of `src_s` are two's-complement values in −128..127. Four products of 0x80 by 0xFF added to a zero accumulator give 0xFFFE0200 in every lane.
- R3: Bytes of the selected word are unsigned values in 0..255. A byte 0xFF multiplies as 255 and never as −1.
- R4: `elem_idx` = k selects bits 32k+31..32k of `src_u`, and that word is shared by all lanes. Within the word, byte b occupies bits 8b+7..8b, so bits 7:0 hold byte 0.
- R5: Lanes are independent. A wrap in one lane never changes a neighbouring lane.
- R6: The accumulation wraps with no saturation. For example, 0x7FFFFFFF plus a product of 1 gives 0x80000000.
- R7: With `wide_mode` = 0, lanes 0 and 1 are computed as in R1 and bits 127:64 of the result are zero. With `wide_mode` = 1, all four lanes are computed.
- R8: `out_valid` equals `in_valid` of the previous cycle. `acc_out` shows the result of an accepted input on the clock after `in_valid` was high.
- R9: A synchronous active-high `rst` clears `out_valid` and `acc_out` to zero.
- R10: In a cycle with `in_valid` low, `acc_out` keeps its previous value.
- R11: When every byte of `src_s` is zero, the result in 128-bit mode equals `acc_in` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| wide_mode | input | 1 | 1: four lanes (128-bit), 0: two lanes (64-bit) |
| elem_idx | input | 2 | Index of the 32-bit word of `src_u` |
| src_s | input | 128 | Signed byte source |
| src_u | input | 128 | Unsigned byte source, one word of which is used |
| acc_in | input | 128 | Accumulator lanes |
| out_valid | output | 1 | Result valid |
| acc_out | output | 128 | Registered accumulated result |

## Verification
The assertions run on every cycle and cover the cycle-level contract: the valid flag lags its input by one clock, reset clears the outputs, the result holds when no operand arrives, the upper half is zero in 64-bit mode, and a zero signed source leaves the accumulator untouched. Only the bench's scenarios show the arithmetic itself. Its scenarios cover the signed-by-unsigned extremes, the byte order and index selection inside the shared word, the wrap at 0x7FFFFFFF, and the absence of carries between lanes. Those values are checked against a model of R1 that the bench builds from the requirements.

// File: rtl/mixdot_pkg.sv
package mixdot_pkg;
    localparam int unsigned VEC_W      = 128;
    localparam int unsigned LANE_W     = 32;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned LANES      = VEC_W / LANE_W;
    localparam int unsigned BYTES_LANE = LANE_W / BYTE_W;
    localparam int unsigned IDX_W      = $clog2(LANES);
    localparam int unsigned PROD_W     = 2 * BYTE_W + 2;

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        DSZ_HALF = 1'b0,
        DSZ_FULL = 1'b1
    } dsize_e;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] data;
    } result_t;

    // signed byte times unsigned byte, widened to a lane with sign extension
    function automatic lane_t su_product(input byte_t s, input byte_t u);
        logic signed [BYTE_W:0]   s_ext;
        logic signed [BYTE_W:0]   u_ext;
        logic signed [PROD_W-1:0] p;
        s_ext = {s[BYTE_W-1], s};
        u_ext = {1'b0, u};
        p     = PROD_W'(s_ext) * PROD_W'(u_ext);
        return {{(LANE_W-PROD_W){p[PROD_W-1]}}, p};
    endfunction
endpackage

// File: rtl/mixdot_word_pick.sv
module mixdot_word_pick
    import mixdot_pkg::*;
#(
    parameter int unsigned W_VEC  = VEC_W,
    parameter int unsigned W_LANE = LANE_W,
    localparam int unsigned N_WORDS = W_VEC / W_LANE,
    localparam int unsigned W_IDX   = $clog2(N_WORDS)
) (
    input  logic [W_VEC-1:0]  vec,
    input  logic [W_IDX-1:0]  idx,
    output logic [W_LANE-1:0] word
);
    logic [W_LANE-1:0] words [N_WORDS];

    for (genvar k = 0; k < N_WORDS; k++) begin : g_split
        assign words[k] = vec[k*W_LANE +: W_LANE];
    end

    always_comb begin
        word = '0;
        for (int k = 0; k < N_WORDS; k++) begin
            if (idx == W_IDX'(k)) word = words[k];
        end
    end
endmodule

// File: rtl/mixdot_lane.sv
module mixdot_lane
    import mixdot_pkg::*;
#(
    parameter int unsigned N_BYTES = BYTES_LANE
) (
    input  lane_t s_word,
    input  lane_t u_word,
    input  lane_t acc,
    output lane_t sum
);
    lane_t prods [N_BYTES];

    for (genvar b = 0; b < N_BYTES; b++) begin : g_prod
        assign prods[b] = su_product(s_word[b*BYTE_W +: BYTE_W],
                                     u_word[b*BYTE_W +: BYTE_W]);
    end

    always_comb begin
        sum = acc;
        for (int b = 0; b < N_BYTES; b++) begin
            sum = sum + prods[b];
        end
    end
endmodule

// File: rtl/mixdot_unit.sv
module mixdot_unit
    import mixdot_pkg::*;
#(
    parameter int unsigned W_VEC  = VEC_W,
    parameter int unsigned W_LANE = LANE_W,
    localparam int unsigned N_LANES = W_VEC / W_LANE,
    localparam int unsigned W_IDX   = $clog2(N_LANES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             wide_mode,
    input  logic [W_IDX-1:0] elem_idx,
    input  logic [W_VEC-1:0] src_s,
    input  logic [W_VEC-1:0] src_u,
    input  logic [W_VEC-1:0] acc_in,
    output logic             out_valid,
    output logic [W_VEC-1:0] acc_out
);
    dsize_e      dsize;
    lane_t       shared_word;
    logic [W_VEC-1:0] next_vec;
    result_t     res_q;

    assign dsize = dsize_e'(wide_mode);

    mixdot_word_pick #(.W_VEC(W_VEC), .W_LANE(W_LANE)) pick_i (
        .vec  (src_u),
        .idx  (elem_idx),
        .word (shared_word)
    );

    for (genvar e = 0; e < N_LANES; e++) begin : g_lane
        lane_t lane_sum;
        mixdot_lane lane_i (
            .s_word (src_s[e*W_LANE +: W_LANE]),
            .u_word (shared_word),
            .acc    (acc_in[e*W_LANE +: W_LANE]),
            .sum    (lane_sum)
        );
        if (e < N_LANES / 2) begin : g_low
            assign next_vec[e*W_LANE +: W_LANE] = lane_sum;
        end else begin : g_high
            assign next_vec[e*W_LANE +: W_LANE] =
                (dsize == DSZ_FULL) ? lane_sum : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.vld <= in_valid;
            if (in_valid) res_q.data <= next_vec;
        end
    end

    assign out_valid = res_q.vld;
    assign acc_out   = res_q.data;

    // R8: valid lags its input by one clock
    p_valid_lag_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    // R9: reset clears outputs
    p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && acc_out == '0));

    // R10: no valid input, result held
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(in_valid)) |-> $stable(acc_out));

    // R7: half width leaves upper half zero
    p_half_upper_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && !$past(wide_mode))
            |-> (acc_out[W_VEC-1:W_VEC/2] == '0));

    // R11: zero signed source passes accumulator through
    p_zero_src_r11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && $past(wide_mode) && $past(src_s) == '0)
            |-> (acc_out == $past(acc_in)));
endmodule

// File: tb/mixdot_unit_tb.sv
module mixdot_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         wide_mode;
    logic [1:0]   elem_idx;
    logic [127:0] src_s, src_u, acc_in;
    logic         out_valid;
    logic [127:0] acc_out;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    mixdot_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .wide_mode(wide_mode),
        .elem_idx(elem_idx), .src_s(src_s), .src_u(src_u), .acc_in(acc_in),
        .out_valid(out_valid), .acc_out(acc_out)
    );

    typedef struct packed {
        logic [127:0] s;
        logic [127:0] u;
        logic [127:0] acc;
        logic [1:0]   idx;
        logic         wide;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{128'h0102030405060708090A0B0C0D0E0F10, 128'h00000000FF80017F1122334455667788,
          128'h00000001000000020000000300000004, 2'd2, 1'b1},
        '{128'hFFFEFDFC7F7F7F7F8080808001FF02FE, 128'hFFFFFFFF000000000000000000000000,
          128'h10000000200000003000000040000000, 2'd3, 1'b1},
        '{128'hDEADBEEFCAFEBABE0123456789ABCDEF, 128'h13579BDF2468ACE0FEDCBA9876543210,
          128'h7FFFFFFF80000000FFFFFFFF00000000, 2'd0, 1'b1},
        '{128'h11111111222222223333333344444444, 128'h00000000AABBCCDD0000000000000000,
          128'h00000005000000060000000700000008, 2'd1, 1'b1},
        '{128'h8181818101010101F0F0F0F00F0F0F0F, 128'h0F0F0F0FF0F0F0F055AA55AA01020304,
          128'hAAAAAAAABBBBBBBBCCCCCCCCDDDDDDDD, 2'd0, 1'b0},
        '{128'h00000000000000007F80FF01807F01FF, 128'h00000000000000000000000080FF017F,
          128'h12345678123456781234567812345678, 2'd0, 1'b0}
    };

    // independent model of R1 / R7
    function automatic logic [127:0] model(input logic [127:0] s, input logic [127:0] u,
                                           input logic [127:0] a, input logic [1:0] idx,
                                           input logic wide);
        logic [127:0] r;
        logic [31:0]  w;
        logic [31:0]  lane;
        r = '0;
        w = u[idx*32 +: 32];
        for (int e = 0; e < 4; e++) begin
            if (wide || e < 2) begin
                lane = a[e*32 +: 32];
                for (int b = 0; b < 4; b++) begin
                    int sv, uv;
                    sv = int'($signed(s[e*32 + b*8 +: 8]));
                    uv = int'({24'd0, w[b*8 +: 8]});
                    lane = lane + 32'(sv * uv);
                end
                r[e*32 +: 32] = lane;
            end
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // drive one operation, check result one clock later
    task automatic run_op(input string req, input logic [127:0] s, input logic [127:0] u,
                          input logic [127:0] a, input logic [1:0] idx, input logic wide,
                          input logic [127:0] exp);
        @(negedge clk);
        src_s = s; src_u = u; acc_in = a; elem_idx = idx; wide_mode = wide; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " valid"}, {127'd0, out_valid}, 128'd1);
        chk(req, acc_out, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog act=hung exp=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; wide_mode = 1'b1; elem_idx = '0;
        src_s = '0; src_u = '0; acc_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        chk("R9 out_valid", {127'd0, out_valid}, 128'd0);
        chk("R9 acc_out", acc_out, 128'd0);

        // table walk, R1 / R7 / R8
        for (int i = 0; i < NV; i++) begin
            run_op("R1 table", VECS[i].s, VECS[i].u, VECS[i].acc, VECS[i].idx, VECS[i].wide,
                   model(VECS[i].s, VECS[i].u, VECS[i].acc, VECS[i].idx, VECS[i].wide));
        end

        // R2 and R3: 0x80 * 0xFF in all four products
        run_op("R2 R3 extreme", {16{8'h80}}, {16{8'hFF}}, '0, 2'd1, 1'b1, {4{32'hFFFE0200}});

        // R3: 0xFF unsigned times +1 gives +255
        run_op("R3 unsigned", {4{32'h00000001}}, {96'd0, 32'h000000FF}, '0, 2'd0, 1'b1,
               {4{32'h000000FF}});

        // R4: index selection, all signed bytes one, word k has bytes k+1
        for (int k = 0; k < 4; k++) begin
            run_op("R4 index", {16{8'h01}}, 128'h04040404030303030202020201010101, '0,
                   2'(k), 1'b1, {4{32'(4 * (k + 1))}});
        end

        // R4: byte order inside the shared word
        run_op("R4 byte order", {32'h00010000, 32'h00000100, 32'h01000000, 32'h00000001},
               {96'd0, 32'h04030201}, '0, 2'd0, 1'b1,
               {32'd3, 32'd2, 32'd4, 32'd1});

        // R6: wrap from 0x7FFFFFFF
        run_op("R6 wrap", {96'd0, 32'h00000001}, {96'd0, 32'h00000001},
               {96'd0, 32'h7FFFFFFF}, 2'd0, 1'b1, {96'd0, 32'h80000000});

        // R5: lane 0 wraps to zero, lane 1 untouched
        run_op("R5 no carry", {96'd0, 32'h00000001}, {96'd0, 32'h00000001},
               {64'd0, 32'h00000000, 32'hFFFFFFFF}, 2'd0, 1'b1, 128'd0);

        // R11: zero signed source, accumulator passes through
        run_op("R11 zero src", '0, {16{8'hFF}}, 128'hCAFEF00D_DEADBEEF_01234567_89ABCDEF,
               2'd3, 1'b1, 128'hCAFEF00D_DEADBEEF_01234567_89ABCDEF);

        // R7: half width with nonzero upper accumulator
        run_op("R7 half", {16{8'h02}}, {96'd0, 32'h01010101},
               {32'h11111111, 32'h22222222, 32'h00000010, 32'h00000020}, 2'd0, 1'b0,
               {64'd0, 32'h00000018, 32'h00000028});

        // R10: idle cycle with changed operands, output held
        @(negedge clk);
        src_s = {16{8'h7F}}; src_u = {16{8'hFF}}; acc_in = {4{32'h5}}; wide_mode = 1'b1;
        @(negedge clk);
        chk("R8 idle valid", {127'd0, out_valid}, 128'd0);
        chk("R10 hold", acc_out, {64'd0, 32'h00000018, 32'h00000028});

        // R9: reset after activity
        @(negedge clk);
        in_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b0;
        chk("R9 mid reset valid", {127'd0, out_valid}, 128'd0);
        chk("R9 mid reset data", acc_out, 128'd0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule